// File: doc/BRIEF.md
# Dual-Input Up/Down Binary Counter

This block is a presettable binary counter with two count inputs: one that counts up and one that counts down. It runs on a single system clock. Each count input passes through a two-flop synchronizer. A rising edge on a count input moves the counter one step in that direction, but only while the other count input rests HIGH. Rising edges on both inputs in the same cycle cancel out.

A synchronous active-low load copies the data bus into the counter. A synchronous active-high clear forces it to zero. Clear outranks load, and load outranks counting.

Two active-low outputs let stages be chained into wider counters:
- `carry_n` goes low while the counter sits at its maximum and the synchronized up input is LOW.
- `borrow_n` goes low while the counter sits at zero and the synchronized down input is LOW.

Feeding `carry_n` to the next stage's up input and `borrow_n` to its down input gives a wider up/down counter. Each link in such a chain adds synchronizer latency.

Top module: `udc_counter`

## Requirements
- R1: After reset, `count` is 0, and `carry_n` and `borrow_n` are both 1.
- R2: A LOW-to-HIGH change on `up_in` adds one to `count`, wrapping from the all-ones value to 0. `count` shows the new value after the third rising clock edge that follows the input change (two synchronizer stages plus the counter register).
- R3: A LOW-to-HIGH change on `dn_in` subtracts one from `count`, wrapping from 0 to the all-ones value, with the same latency as R2.
- R4: A rising edge on one count input while the other count input is LOW leaves `count` unchanged.
- R5: While `load_n` is 0 and `clr` is 0, `count` takes the value of `data` at each clock edge. Count edges seen while `load_n` is 0 are discarded.
- R6: While `clr` is 1, `count` becomes 0 at the next clock edge, whatever the values of `load_n`, `data` and the count inputs.
- R7: When rising edges on both count inputs reach the counter in the same cycle, `count` holds its value.
- R8: `carry_n` is 0 exactly when `count` is all ones and the synchronized `up_in` is LOW. It falls two clock edges after `up_in` falls.
- R9: `borrow_n` is 0 exactly when `count` is 0 and the synchronized `dn_in` is LOW.
- R10: With `carry_n` driving a second stage's `up_in` and `borrow_n` driving its `dn_in`, the two stages count as one 8-bit up/down counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear to zero, active high, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| data | input | WIDTH | Preset value for load |
| up_in | input | 1 | Count-up input; rising edge counts up |
| dn_in | input | 1 | Count-down input; rising edge counts down |
| count | output | WIDTH | Current counter value |
| carry_n | output | 1 | Active-low carry, gated by the up input at the maximum |
| borrow_n | output | 1 | Active-low borrow, gated by the down input at zero |

## Verification
The bench builds two copies of the counter with the defaults: WIDTH = 4 and two synchronizer stages. The second copy is chained to the first through `carry_n` and `borrow_n`. The 4-bit width makes both wrap points reachable within a few pulses, so random sequences of up, down, load, clear and simultaneous pulses cross maximum and zero often. Those crossings drive the second stage and check the cascade. The default synchronizer depth fixes the three-edge count latency and the two-edge carry latency that the directed timing checks sample.

// File: rtl/udc_pkg.sv
package udc_pkg;

  typedef enum logic [2:0] {
    ACT_HOLD  = 3'd0,
    ACT_CLEAR = 3'd1,
    ACT_LOAD  = 3'd2,
    ACT_INC   = 3'd3,
    ACT_DEC   = 3'd4
  } udc_act_e;

  // Priority: clear, then load, then a single qualified count step.
  function automatic udc_act_e pick_action(input logic clr, input logic load_n,
                                           input logic inc, input logic dec);
    udc_act_e a;
    if (clr)             a = ACT_CLEAR;
    else if (!load_n)    a = ACT_LOAD;
    else if (inc && !dec) a = ACT_INC;
    else if (dec && !inc) a = ACT_DEC;
    else                 a = ACT_HOLD;
    return a;
  endfunction

endpackage

// File: rtl/udc_sync.sv
module udc_sync #(
  parameter int  STAGES  = 2,
  parameter bit  RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= RST_VAL;
        else        chain[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= RST_VAL;
        else        chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/udc_edge.sv
module udc_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b1;
    else        prev <= lvl;
  end

  assign rise = lvl & ~prev;

  AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise); // R2
endmodule

// File: rtl/udc_core.sv
module udc_core
  import udc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load_n,
  input  logic [WIDTH-1:0] data,
  input  logic             inc_evt,
  input  logic             dec_evt,
  output logic [WIDTH-1:0] count
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  function automatic logic [WIDTH-1:0] step_up(input logic [WIDTH-1:0] v);
    return v + ONE;
  endfunction

  function automatic logic [WIDTH-1:0] step_dn(input logic [WIDTH-1:0] v);
    return v - ONE;
  endfunction

  udc_act_e act;
  assign act = pick_action(clr, load_n, inc_evt, dec_evt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else begin
      unique case (act)
        ACT_CLEAR: count <= '0;
        ACT_LOAD:  count <= data;
        ACT_INC:   count <= step_up(count);
        ACT_DEC:   count <= step_dn(count);
        default:   count <= count;
      endcase
    end
  end

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> count == '0); // R6
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !load_n) |=> count == $past(data)); // R5
  AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && load_n && inc_evt && !dec_evt) |=> count == WIDTH'($past(count) + ONE)); // R2
  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && load_n && dec_evt && !inc_evt) |=> count == WIDTH'($past(count) - ONE)); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && load_n && !inc_evt && !dec_evt) |=> $stable(count)); // R7
endmodule

// File: rtl/udc_counter.sv
module udc_counter #(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load_n,
  input  logic [WIDTH-1:0] data,
  input  logic             up_in,
  input  logic             dn_in,
  output logic [WIDTH-1:0] count,
  output logic             carry_n,
  output logic             borrow_n
);
  localparam logic [WIDTH-1:0] MAX_VAL = {WIDTH{1'b1}};

  function automatic logic at_max(input logic [WIDTH-1:0] v);
    return v == MAX_VAL;
  endfunction

  function automatic logic at_zero(input logic [WIDTH-1:0] v);
    return v == '0;
  endfunction

  logic up_lvl, dn_lvl;
  logic up_rise, dn_rise;
  logic inc_evt, dec_evt;

  udc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_up (
    .clk(clk), .rst_n(rst_n), .d(up_in), .q(up_lvl));
  udc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_dn (
    .clk(clk), .rst_n(rst_n), .d(dn_in), .q(dn_lvl));

  udc_edge u_edge_up (.clk(clk), .rst_n(rst_n), .lvl(up_lvl), .rise(up_rise));
  udc_edge u_edge_dn (.clk(clk), .rst_n(rst_n), .lvl(dn_lvl), .rise(dn_rise));

  // A step counts only while the opposite input rests HIGH; simultaneous rises cancel.
  assign inc_evt = up_rise & dn_lvl & ~dn_rise;
  assign dec_evt = dn_rise & up_lvl & ~up_rise;

  udc_core #(.WIDTH(WIDTH)) u_core (
    .clk(clk), .rst_n(rst_n), .clr(clr), .load_n(load_n), .data(data),
    .inc_evt(inc_evt), .dec_evt(dec_evt), .count(count));

  assign carry_n  = ~(at_max(count)  & ~up_lvl);
  assign borrow_n = ~(at_zero(count) & ~dn_lvl);

  AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({inc_evt, dec_evt})); // R7
  AST_CARRY_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(carry_n) |-> count == MAX_VAL); // R8
  AST_BORROW_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(borrow_n) |-> count == '0); // R9
  AST_BLOCKED_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (up_rise && !dn_lvl) |-> !inc_evt); // R4
endmodule

// File: tb/tb_udc_counter.sv
module tb_udc_counter;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;

  logic clk = 0;
  logic rst_n = 0;
  logic clr = 0, load_n = 1, up_in = 1, dn_in = 1;
  logic [W-1:0] data = '0;
  logic [W-1:0] count, hi_count;
  logic carry_n, borrow_n, hi_carry_n, hi_borrow_n;
  logic hi_clr = 0, hi_load_n = 1;
  logic [W-1:0] hi_data = '0;

  int checks = 0, errors = 0;
  int lo_m = 0, hi_m = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  udc_counter dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .load_n(load_n), .data(data),
    .up_in(up_in), .dn_in(dn_in), .count(count),
    .carry_n(carry_n), .borrow_n(borrow_n));

  udc_counter dut_hi (
    .clk(clk), .rst_n(rst_n), .clr(hi_clr), .load_n(hi_load_n), .data(hi_data),
    .up_in(carry_n), .dn_in(borrow_n), .count(hi_count),
    .carry_n(hi_carry_n), .borrow_n(hi_borrow_n));

  function automatic int wrap(input int v);
    return ((v % 16) + 16) % 16;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (12) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_up();
    @(negedge clk) up_in = 0;
    repeat (4) @(posedge clk);
    @(negedge clk) up_in = 1;
    settle();
  endtask

  task automatic pulse_dn();
    @(negedge clk) dn_in = 0;
    repeat (4) @(posedge clk);
    @(negedge clk) dn_in = 1;
    settle();
  endtask

  task automatic pulse_both();
    @(negedge clk) begin up_in = 0; dn_in = 0; end
    repeat (4) @(posedge clk);
    @(negedge clk) begin up_in = 1; dn_in = 1; end
    settle();
  endtask

  task automatic load_lo(input int v);
    @(negedge clk) begin load_n = 0; data = W'(v); end
    @(negedge clk) load_n = 1;
    settle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 count", count, 0);
    chk("R1 carry_n", carry_n, 1);
    chk("R1 borrow_n", borrow_n, 1);
    rst_n = 1;
    settle();

    // R2 latency: new value after the third clock edge
    @(negedge clk) up_in = 0;
    repeat (4) @(posedge clk);
    @(negedge clk) up_in = 1;
    repeat (2) @(posedge clk);
    @(negedge clk) chk("R2 before third edge", count, 0);
    @(posedge clk); @(negedge clk) chk("R2 after third edge", count, 1);
    settle();

    // R3 down and wrap from 0
    load_lo(0);
    chk("R5 load 0", count, 0);
    @(negedge clk) hi_clr = 1;
    @(negedge clk) hi_clr = 0;
    // R9 borrow low at zero while dn low
    @(negedge clk) dn_in = 0;
    @(posedge clk); @(negedge clk) chk("R9 borrow still high", borrow_n, 1);
    @(posedge clk); @(negedge clk) chk("R9 borrow low", borrow_n, 0);
    @(negedge clk) dn_in = 1;
    settle();
    chk("R3 wrap 0 to 15", count, 15);
    chk("R10 high stage down", hi_count, 15);

    // R8 carry low at 15 while up low; R2 wrap
    @(negedge clk) up_in = 0;
    @(posedge clk); @(negedge clk) chk("R8 carry still high", carry_n, 1);
    @(posedge clk); @(negedge clk) chk("R8 carry low", carry_n, 0);
    chk("R8 count held at max", count, 15);
    @(negedge clk) up_in = 1;
    settle();
    chk("R2 wrap 15 to 0", count, 0);
    chk("R8 carry released", carry_n, 1);
    chk("R10 high stage up", hi_count, 0);

    // R4 up edge while dn low is ignored; dn edge then counts down
    load_lo(7);
    @(negedge clk) dn_in = 0;
    settle();
    pulse_up();
    chk("R4 up blocked by low dn", count, 7);
    @(negedge clk) dn_in = 1;
    settle();
    chk("R3 dn rise counts", count, 6);

    // R7 both rises cancel
    pulse_both();
    chk("R7 simultaneous hold", count, 6);

    // R5 load held low across a count pulse
    @(negedge clk) begin load_n = 0; data = 4'd11; end
    @(negedge clk) up_in = 0;
    repeat (4) @(posedge clk);
    @(negedge clk) up_in = 1;
    repeat (6) @(posedge clk);
    @(negedge clk) chk("R5 load wins over count", count, 11);
    load_n = 1;
    settle();
    chk("R5 edge during load discarded", count, 11);

    // R6 clear overrides load
    @(negedge clk) begin clr = 1; load_n = 0; data = 4'd9; end
    @(posedge clk); @(negedge clk) chk("R6 clear over load", count, 0);
    load_n = 1;
    @(negedge clk) up_in = 0;
    repeat (4) @(posedge clk);
    @(negedge clk) up_in = 1;
    repeat (6) @(posedge clk);
    @(negedge clk) clr = 0;
    settle();
    chk("R6 clear over count", count, 0);

    // Random mix against model, high stage cascaded (R10)
    @(negedge clk) begin hi_load_n = 0; hi_data = 4'd5; end
    @(negedge clk) hi_load_n = 1;
    settle();
    lo_m = 0; hi_m = 5;
    for (int i = 0; i < 150; i++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op < 4) begin
        if (lo_m == 15) hi_m = wrap(hi_m + 1);
        pulse_up(); lo_m = wrap(lo_m + 1);
        chk("R2 random up", count, lo_m);
      end else if (op < 8) begin
        if (lo_m == 0) hi_m = wrap(hi_m - 1);
        pulse_dn(); lo_m = wrap(lo_m - 1);
        chk("R3 random down", count, lo_m);
      end else if (op == 8) begin
        int v;
        v = $urandom_range(0, 15);
        load_lo(v); lo_m = v;
        chk("R5 random load", count, lo_m);
      end else begin
        if (lo_m == 15) hi_m = wrap(hi_m + 1);
        if (lo_m == 0)  hi_m = wrap(hi_m - 1);
        pulse_both();
        chk("R7 random both", count, lo_m);
      end
      chk("R10 random high stage", hi_count, hi_m);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule